// File: doc/BRIEF.md
# Averaging Dual-Mixer Phase Calibrator

This block estimates the phase offset between a reference clock and one of up to sixteen compare clocks. It uses the digital dual-mixer time-difference method. The block runs on a slightly detuned offset clock, which samples every input. After synchronisation and a three-sample majority filter, the block finds the rising edges of the reference stream and of the selected compare stream. It counts the offset-clock cycles from each reference edge to the next compare edge, and that count is one sample.

The block sums the samples over a programmable set size. A sequential divider then turns the sum into the mean. The mean is published as a phase value, and a sticky ready flag is raised, both on a status word and on a dedicated output pin. Software controls the block through two 32-bit words on a minimal write/read port: a control word and a status word.

A divider pass takes one cycle per dividend bit. If a set completes while the previous division is still running, that set is dropped.

Top module: `dmtd_phase_cal`

## Requirements
- R1: After reset, the control word (address 0) and the status word (address 1) both read as zero, and `phase_ready` is low.
- R2: Control word layout: bit 0 is enable, bits 11:8 select the compare input, and bits 27:16 hold the set size. A read returns these fields as written, and every other bit reads 0.
- R3: One sample is the number of offset-clock cycles from a reference rising edge to the next rising edge of the selected compare stream. Coincident edges give a sample of 0. After a set of N samples, status bits 23:0 hold floor(sum/N).
- R4: A set size of 0 behaves as a set size of 1.
- R5: The select field picks which compare input is measured. Writing a different select value while enabled discards the partial sum, and a fresh set begins.
- R6: While the enable bit is 0, no samples are accumulated and no result is produced. Clearing the enable bit discards the partial sum.
- R7: Status bit 24 and the `phase_ready` pin go high when a new result is stored, and stay high until cleared. Writing 1 to status bit 24 clears them. Writing 0 to bit 24 has no effect. The phase field cannot be written from the bus.
- R8: If a new result arrives in the same cycle as a bus clear of the ready flag, the flag stays set.
- R9: A one-cycle pulse on a sampled stream, with lows on both sides, is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Offset clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock, sampled asynchronously |
| cmp_clk_i | input | NCMP | Compare clocks, sampled asynchronously |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 1 | Word select: 0 control, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| phase_ready | output | 1 | Copy of the sticky ready flag |

## Verification
The ready flag has two writers that can act in the same cycle: the divider storing a new result sets it, and a bus write of 1 to bit 24 clears it. To provoke the collision, the bench first runs a measurement and records the cycle in which `phase_ready` rises. It then repeats the identical stimulus, with the same control writes at the same offsets, and places the clear write so that it lands exactly on that cycle. A correct design must show the flag still high after that cycle, and a separate later clear must drop it.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int  BUS_W     = 32;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int  EN_BIT    = 0;
  localparam int  SEL_LSB   = 8;
  localparam int  SEL_FW    = 4;
  localparam int  NAVG_LSB  = 16;
  localparam int  RDY_BIT   = 24;
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/dpc_edge_det.sv
module dpc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [2:0] tap;
  logic       lvl;
  logic       maj;

  assign maj  = (tap[0] & tap[1]) | (tap[0] & tap[2]) | (tap[1] & tap[2]);
  assign rise = maj & ~lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap <= '0;
      lvl <= 1'b0;
    end else begin
      tap <= {tap[1:0], din};
      lvl <= maj;
    end
  end
endmodule

// File: rtl/dpc_tdc.sv
module dpc_tdc #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ref_rise,
  input  logic         cmp_rise,
  output logic         smp_valid,
  output logic [W-1:0] smp_val
);
  logic         armed;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed     <= 1'b0;
      cnt       <= '0;
      smp_valid <= 1'b0;
      smp_val   <= '0;
    end else begin
      smp_valid <= 1'b0;
      if (ref_rise) begin
        cnt   <= W'(1);
        armed <= !cmp_rise;
        if (cmp_rise) begin
          smp_valid <= 1'b1;
          smp_val   <= '0;
        end
      end else if (armed) begin
        if (cmp_rise) begin
          smp_valid <= 1'b1;
          smp_val   <= cnt;
          armed     <= 1'b0;
        end else if (cnt != '1) begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dpc_div.sv
module dpc_div #(
  parameter int NW = 36,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int STEP_W = $clog2(NW + 1);

  logic [STEP_W-1:0] step;
  logic [DW-1:0]     rem;
  logic [DW-1:0]     dvs;
  logic [NW-1:0]     q;
  logic [DW:0]       trial;
  logic [DW:0]       diff;
  logic              ge;

  assign trial = {rem, q[NW-1]};
  assign diff  = trial - {1'b0, dvs};
  assign ge    = trial >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
      rem  <= '0;
      dvs  <= '0;
      q    <= '0;
      quot <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        q    <= dividend;
        rem  <= '0;
        dvs  <= divisor;
        step <= STEP_W'(NW);
      end else if (busy) begin
        q    <= {q[NW-2:0], ge};
        rem  <= ge ? diff[DW-1:0] : trial[DW-1:0];
        step <= step - STEP_W'(1);
        if (step == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quot <= {q[NW-2:0], ge};
        end
      end
    end
  end
endmodule

// File: rtl/dmtd_phase_cal.sv
module dmtd_phase_cal
  import dpc_pkg::*;
#(
  parameter int NCMP    = 16,
  parameter int PHASE_W = 24,
  parameter int NAVG_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk_i,
  input  logic [NCMP-1:0]  cmp_clk_i,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             phase_ready
);
  localparam int ACC_W = PHASE_W + NAVG_W;
  localparam int SEL_N = 1 << SEL_FW;

  logic              en_q;
  logic [SEL_FW-1:0] sel_q;
  logic [NAVG_W-1:0] navg_q;
  logic [PHASE_W-1:0] phase_q;
  logic              ready_q;

  logic [NCMP:0]     syn;
  logic [SEL_N-1:0]  cmp_pad;
  logic              cmp_pick;
  logic              ref_rise, cmp_rise;
  logic              smp_valid;
  logic [PHASE_W-1:0] smp_val;

  logic [ACC_W-1:0]  acc_q, acc_nx, div_num;
  logic [NAVG_W-1:0] nsamp_q, navg_eff, div_den;
  logic [NAVG_W:0]   nsamp_nx;
  logic              div_go, div_busy, div_done;
  logic [ACC_W-1:0]  div_quot;

  logic ctrl_wr, stat_clr, sel_chg, flush, set_end;
  logic [BUS_W-1:0] ctrl_word, stat_word;
  logic unused_bits;

  assign unused_bits = ^{bus_wdata, div_quot};

  dpc_sync #(.W(NCMP + 1)) u_sync (
    .clk(clk), .rst(rst), .din({cmp_clk_i, ref_clk_i}), .dout(syn)
  );

  generate
    for (genvar k = 0; k < SEL_N; k++) begin : g_pad
      if (k < NCMP) begin : g_live
        assign cmp_pad[k] = syn[k+1];
      end else begin : g_tie
        assign cmp_pad[k] = 1'b0;
      end
    end
  endgenerate

  assign cmp_pick = cmp_pad[sel_q];

  dpc_edge_det u_ref_edge (.clk(clk), .rst(rst), .din(syn[0]),   .rise(ref_rise));
  dpc_edge_det u_cmp_edge (.clk(clk), .rst(rst), .din(cmp_pick), .rise(cmp_rise));

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
  assign stat_clr = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[RDY_BIT];
  assign sel_chg  = ctrl_wr && (bus_wdata[SEL_LSB +: SEL_FW] != sel_q);
  assign flush    = !en_q || sel_chg;

  dpc_tdc #(.W(PHASE_W)) u_tdc (
    .clk(clk), .rst(rst), .clr(flush),
    .ref_rise(ref_rise), .cmp_rise(cmp_rise),
    .smp_valid(smp_valid), .smp_val(smp_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      navg_q <= '0;
    end else if (ctrl_wr) begin
      en_q   <= bus_wdata[EN_BIT];
      sel_q  <= bus_wdata[SEL_LSB +: SEL_FW];
      navg_q <= bus_wdata[NAVG_LSB +: NAVG_W];
    end
  end

  assign navg_eff = (navg_q == '0) ? NAVG_W'(1) : navg_q;
  assign nsamp_nx = {1'b0, nsamp_q} + (NAVG_W + 1)'(1);
  assign acc_nx   = acc_q + ACC_W'(smp_val);
  assign set_end  = nsamp_nx >= {1'b0, navg_eff};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc_q   <= '0;
      nsamp_q <= '0;
      div_go  <= 1'b0;
      div_num <= '0;
      div_den <= '0;
    end else begin
      div_go <= 1'b0;
      if (smp_valid) begin
        if (set_end) begin
          div_go  <= 1'b1;
          div_num <= acc_nx;
          div_den <= navg_eff;
          acc_q   <= '0;
          nsamp_q <= '0;
        end else begin
          acc_q   <= acc_nx;
          nsamp_q <= nsamp_nx[NAVG_W-1:0];
        end
      end
    end
  end

  dpc_div #(.NW(ACC_W), .DW(NAVG_W)) u_div (
    .clk(clk), .rst(rst), .clr(flush), .start(div_go),
    .dividend(div_num), .divisor(div_den),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      ready_q <= 1'b0;
    end else begin
      if (div_done) phase_q <= div_quot[PHASE_W-1:0];
      if (div_done)      ready_q <= 1'b1;
      else if (stat_clr) ready_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_BIT] = en_q;
    ctrl_word[SEL_LSB +: SEL_FW] = sel_q;
    ctrl_word[NAVG_LSB +: NAVG_W] = navg_q;
    stat_word = '0;
    stat_word[0 +: PHASE_W] = phase_q;
    stat_word[RDY_BIT] = ready_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= (bus_addr == ADDR_CTRL) ? ctrl_word : stat_word;
  end

  assign phase_ready = ready_q;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
  import dpc_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int NAVG_W  = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic                      bus_addr,
  input logic                      clr_bit,
  input logic                      phase_ready,
  input logic                      div_done,
  input logic                      en_q,
  input logic [PHASE_W+NAVG_W-1:0] acc_q,
  input logic [NAVG_W-1:0]         nsamp_q,
  input logic [PHASE_W-1:0]        phase_q
);
  logic stat_clr;
  assign stat_clr = bus_wr && (bus_addr == ADDR_STAT) && clr_bit;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    div_done |=> phase_ready);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_ready && !stat_clr) |=> phase_ready);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !div_done) |=> !phase_ready);

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !div_done |=> $stable(phase_q));

  p_disable_flush_r6: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (acc_q == '0 && nsamp_q == '0));
endmodule

bind dmtd_phase_cal dpc_checker #(.PHASE_W(PHASE_W), .NAVG_W(NAVG_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .clr_bit(bus_wdata[dpc_pkg::RDY_BIT]), .phase_ready(phase_ready),
  .div_done(div_done), .en_q(en_q), .acc_q(acc_q), .nsamp_q(nsamp_q),
  .phase_q(phase_q)
);

// File: tb/sim_dmtd_phase_cal.sv
module sim_dmtd_phase_cal;
  localparam int NC = 4;
  localparam int P  = 32;
  localparam int H  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          ref_i = 1'b0;
  logic [NC-1:0] cmp_i = '0;
  logic          bus_wr = 1'b0;
  logic          bus_addr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          rdy;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int rise_cyc = -1;
  logic rdy_prev = 1'b0;
  int dseq [16];
  bit glitch = 1'b0;
  bit done = 1'b0;

  dmtd_phase_cal #(.NCMP(NC)) u0 (
    .clk(clk), .rst(rst), .ref_clk_i(ref_i), .cmp_clk_i(cmp_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .phase_ready(rdy)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rdy && !rdy_prev) rise_cyc = cyc;
    rdy_prev = rdy;
  end

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  function automatic logic [31:0] cw(int en, int sel, int n);
    return 32'(en & 1) | (32'(sel & 15) << 8) | (32'(n & 4095) << 16);
  endfunction

  function automatic int avg(int n, int k, int div);
    int s = 0;
    for (int p = 0; p < n; p++) s += dseq[p] + 2 * k;
    return s / div;
  endfunction

  task automatic run_wave(int n);
    for (int p = 0; p < n; p++) begin
      for (int ph = 0; ph < P; ph++) begin
        @(negedge clk);
        ref_i = (ph < H);
        for (int k = 0; k < NC; k++) begin
          int dk = dseq[p] + 2 * k;
          cmp_i[k] = (ph >= dk && ph < dk + H) || (glitch && ph == 1);
        end
      end
    end
    @(negedge clk);
    ref_i = 1'b0; cmp_i = '0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int r_off, s0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 0);
    rd(1'b1, v); chk("R1 status", v, 0);
    chk("R1 ready pin", rdy, 0);
    // R2 field readback, junk bits dropped
    wr(1'b0, cw(1, 2, 5) | 32'h8000_0020);
    rd(1'b0, v); chk("R2 ctrl readback", v, cw(1, 2, 5));
    // R3/R5 sweep over selects and set sizes
    for (int sel = 0; sel < NC; sel++) begin
      for (int ni = 0; ni < 3; ni++) begin
        int n = (ni == 0) ? 1 : (ni == 1 ? 3 : 4);
        for (int p = 0; p < 16; p++) dseq[p] = (p * 3 + sel + n) % 8;
        wr(1'b1, 32'h0100_0000);
        wr(1'b0, cw(1, sel, n));
        repeat (4) @(negedge clk);
        run_wave(n);
        settle();
        chk("R7 ready pin after set", rdy, 1);
        rd(1'b1, v);
        chk("R3 R5 phase", v[23:0], avg(n, sel, n));
        chk("R7 ready bit", v[24], 1);
      end
    end
    // R7 sticky, write 0 no effect, phase read-only
    repeat (60) @(negedge clk);
    chk("R7 sticky", rdy, 1);
    rd(1'b1, v); s0 = v[23:0];
    wr(1'b1, 32'h00FF_FFFF);
    rd(1'b1, v);
    chk("R7 phase not writable", v[23:0], s0);
    chk("R7 write 0 keeps ready", v[24], 1);
    wr(1'b1, 32'h0100_0000);
    rd(1'b1, v);
    chk("R7 cleared bit", v[24], 0);
    chk("R7 cleared pin", rdy, 0);
    // R4 size 0 acts as 1
    dseq[0] = 11;
    wr(1'b0, cw(1, 0, 0));
    repeat (4) @(negedge clk);
    run_wave(1); settle();
    rd(1'b1, v);
    chk("R4 zero size ready", v[24], 1);
    chk("R4 zero size phase", v[23:0], 11);
    wr(1'b1, 32'h0100_0000);
    // R6 disable discards partial sum
    for (int p = 0; p < 16; p++) dseq[p] = 2;
    wr(1'b0, cw(1, 1, 4));
    repeat (4) @(negedge clk);
    run_wave(2);
    wr(1'b0, cw(0, 1, 4));
    run_wave(4); settle();
    chk("R6 no result while disabled", rdy, 0);
    wr(1'b0, cw(1, 1, 4));
    for (int p = 0; p < 16; p++) dseq[p] = 7 - p;
    repeat (4) @(negedge clk);
    run_wave(4); settle();
    rd(1'b1, v);
    chk("R6 fresh set after enable", v[23:0], avg(4, 1, 4));
    wr(1'b1, 32'h0100_0000);
    // R5 select change discards partial sum
    for (int p = 0; p < 16; p++) dseq[p] = 0;
    wr(1'b0, cw(1, 0, 4));
    repeat (4) @(negedge clk);
    run_wave(2);
    wr(1'b0, cw(1, 3, 4));
    for (int p = 0; p < 16; p++) dseq[p] = p + 1;
    repeat (4) @(negedge clk);
    run_wave(4); settle();
    rd(1'b1, v);
    chk("R5 restart on select change", v[23:0], avg(4, 3, 4));
    wr(1'b1, 32'h0100_0000);
    // R9 glitch ignored
    dseq[0] = 6; dseq[1] = 9;
    glitch = 1'b1;
    wr(1'b0, cw(1, 0, 2));
    repeat (4) @(negedge clk);
    run_wave(2); settle();
    glitch = 1'b0;
    rd(1'b1, v);
    chk("R9 glitch filtered", v[23:0], 7);
    wr(1'b1, 32'h0100_0000);
    // R8 set and clear in the same cycle, run A
    dseq[0] = 3; dseq[1] = 5; dseq[2] = 4;
    wr(1'b0, cw(0, 1, 3));
    wr(1'b0, cw(1, 1, 3));
    rise_cyc = -1;
    s0 = cyc;
    run_wave(3); settle();
    r_off = rise_cyc - s0;
    rd(1'b1, v);
    chk("R8 reference run phase", v[23:0], avg(3, 1, 3));
    wr(1'b1, 32'h0100_0000);
    // run B, clear lands on the set cycle
    wr(1'b0, cw(0, 1, 3));
    wr(1'b0, cw(1, 1, 3));
    s0 = cyc;
    fork
      run_wave(3);
      begin
        @(negedge clk);
        while (cyc != s0 + r_off - 1) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h0100_0000;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
      end
    join
    settle();
    chk("R8 set wins over clear", rdy, 1);
    wr(1'b1, 32'h0100_0000);
    chk("R8 later clear works", rdy, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule